// File: doc/BRIEF.md
# Multiprocessor Interrupt Control Register

A 64-bit control word for a chipset that serves up to four processors. It raises and clears two kinds of per-processor interrupt. The first is a periodic timer interrupt, which a tick input broadcasts to every processor marked present. The second is an inter-processor interrupt (IPI), which one processor posts to another by writing the word. A target processor acknowledges an IPI by writing the same word.

One write can carry three fields at once: timer-clear bits, IPI-request bits and IPI-acknowledge bits. The block applies all fields that are present, in a fixed order. Each processor keeps a saturating count of the IPIs it has not yet acknowledged. Its IPI line stays high until it has acknowledged every one of them.

A write that sets none of the three fields is flagged as unsupported.

Top module: `mp_irq_ctl`

## Requirements
- R1: After reset, the read value, both interrupt vectors and the error flag are all zero.
- R2: Writing 1 to bit 4+i clears timer status bit 4+i and drops timer line i from the next cycle.
- R3: On a tick, every present processor i whose timer line is low gets status bit 4+i set and timer line i raised from the next cycle. Processors that are absent, or whose line is already high, are left unchanged.
- R4: Writing 1 to bit 12+i sets IPI status bit 8+i. It also adds one to processor i's pending count and raises IPI line i when the count leaves zero.
- R5: Writing 1 to bit 8+i clears IPI status bit 8+i. If processor i's pending count is nonzero, the write lowers it by one. IPI line i falls only when the count reaches zero, and an acknowledge at count zero has no effect on the line.
- R6: The fields of one write act in the order timer clear, then IPI request, then IPI acknowledge. A request and an acknowledge to the same processor in one write therefore leave its count and its line unchanged and its status bit clear.
- R7: A write with bits 15:4 all zero pulses the error flag for one cycle, starting the cycle after the write, and changes no state.
- R8: Each pending count is 8 bits wide and saturates at 255. After 256 requests, 254 acknowledges leave the IPI line high and the 255th drops it.
- R9: The read value places timer status in bits 7:4 and IPI status in bits 11:8. All other bits, including the write-only request bits 15:12, read as zero.
- R10: When a tick and a timer-clear for the same processor fall in the same cycle, the clear wins and the line stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 64 | Write data |
| rd_data | output | 64 | Current register value |
| tick | input | 1 | Periodic timer tick, one cycle wide |
| cpu_present | input | NCPU | Mask of processors that exist |
| irq_timer | output | NCPU | Per-processor timer interrupt line |
| irq_ipi | output | NCPU | Per-processor IPI line |
| wr_err | output | 1 | One-cycle pulse after an unsupported write |

## Verification
The hardest state to reach is a saturated pending count. Reaching it needs 256 separate request writes to one processor. The stimulus then has to acknowledge down from 255 and show that the IPI line survives 254 acknowledges and falls on the 255th. A wrapping counter would instead drop the line right after the 256th request.

The other hard case is a single write that both requests and acknowledges for the same processor. This is driven once with a zero count and once with a count of one, so the required order of the two fields shows up on the line.

A tick and a timer clear are also driven into the same cycle, to check which one takes priority.

// File: rtl/mp_irq_ctl.sv
module mp_irq_ctl #(
  parameter int NCPU  = 4,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [63:0]      wr_data,
  output logic [63:0]      rd_data,
  input  logic             tick,
  input  logic [NCPU-1:0]  cpu_present,
  output logic [NCPU-1:0]  irq_timer,
  output logic [NCPU-1:0]  irq_ipi,
  output logic             wr_err
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [NCPU-1:0] tmr_q, ipi_q;
  logic [NCPU-1:0] tmr_clr, ipi_req, ipi_ack;
  logic [3:0]      tmr_f, ipi_f;
  logic            unused_bits;

  assign tmr_clr = wr_en ? wr_data[4  +: NCPU] : '0;
  assign ipi_req = wr_en ? wr_data[12 +: NCPU] : '0;
  assign ipi_ack = wr_en ? wr_data[8  +: NCPU] : '0;
  assign unused_bits = ^{wr_data[63:16], wr_data[3:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmr_q  <= '0;
      ipi_q  <= '0;
      wr_err <= 1'b0;
    end else begin
      tmr_q  <= (tmr_q | ({NCPU{tick}} & cpu_present)) & ~tmr_clr;
      ipi_q  <= (ipi_q | ipi_req) & ~ipi_ack;
      wr_err <= wr_en && (wr_data[15:4] == 12'd0);
    end
  end

  assign irq_timer = tmr_q;
  assign tmr_f     = 4'(tmr_q);
  assign ipi_f     = 4'(ipi_q);
  assign rd_data   = {48'd0, 4'd0, ipi_f, tmr_f, 4'd0};

  for (genvar i = 0; i < NCPU; i++) begin : g_cpu
    logic [CNT_W-1:0] cnt, c_inc, c_nxt;

    assign c_inc = (ipi_req[i] && cnt != CNT_MAX) ? cnt + 1'b1 : cnt;
    assign c_nxt = (ipi_ack[i] && c_inc != '0)    ? c_inc - 1'b1 : c_inc;

    always_ff @(posedge clk) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= c_nxt;
    end

    assign irq_ipi[i] = |cnt;

    // R4
    ipi_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_ipi[i]) |-> $past(wr_en && wr_data[12+i]));
    // R5
    ipi_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_ipi[i]) |-> $past(wr_en && wr_data[8+i]));
    // R6
    ipi_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && wr_data[12+i] && wr_data[8+i] |=> $stable(irq_ipi[i]));
    // R2
    tmr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && wr_data[4+i] |=> !irq_timer[i]);
    // R3
    tmr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick && cpu_present[i] && !(wr_en && wr_data[4+i]) |=> irq_timer[i]);
  end

  // R7
  bad_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_data[15:4] == 12'd0 && !tick |=> $stable(rd_data) && $stable(irq_ipi));
endmodule

// File: tb/mp_irq_ctl_tb.sv
module mp_irq_ctl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [63:0] wr_data = '0;
  logic        tick = 1'b0;
  logic [3:0]  cpu_present = '0;
  logic [63:0] rd_data;
  logic [3:0]  irq_timer, irq_ipi;
  logic        wr_err;
  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  mp_irq_ctl u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .tick(tick), .cpu_present(cpu_present),
    .irq_timer(irq_timer), .irq_ipi(irq_ipi), .wr_err(wr_err));

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(logic w, logic [63:0] d, logic t);
    wr_en = w; wr_data = d; tick = t;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; tick = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 rd", rd_data, 0);
    chk("R1 tmr", 64'(irq_timer), 0);
    chk("R1 ipi", 64'(irq_ipi), 0);
    chk("R1 err", 64'(wr_err), 0);
  endtask

  task automatic t_timer;
    cpu_present = 4'b0101;
    cyc(0, 0, 1);
    chk("R3 partial", 64'(irq_timer), 64'h5);
    chk("R9 tmr", rd_data, 64'h50);
    cpu_present = 4'b1111;
    cyc(0, 0, 1);
    chk("R3 all", 64'(irq_timer), 64'hF);
    cyc(1, 64'h20, 0);
    chk("R2 clr1", 64'(irq_timer), 64'hD);
    chk("R2 rd", rd_data, 64'hD0);
    cyc(1, 64'hF0, 0);
    chk("R2 all", 64'(irq_timer), 0);
  endtask

  task automatic t_tick_clear;
    cyc(1, 64'h20, 1);
    chk("R10", 64'(irq_timer), 64'hD);
    cyc(1, 64'hD0, 0);
    chk("R10 cleanup", 64'(irq_timer), 0);
  endtask

  task automatic t_ipi;
    cyc(1, 64'h2000, 0);
    chk("R4 line", 64'(irq_ipi), 64'h2);
    chk("R4 stat", rd_data, 64'h200);
    cyc(1, 64'h2000, 0);
    cyc(1, 64'h200, 0);
    chk("R5 held", 64'(irq_ipi), 64'h2);
    chk("R5 stat", rd_data, 64'h0);
    cyc(1, 64'h200, 0);
    chk("R5 drop", 64'(irq_ipi), 0);
    cyc(1, 64'h200, 0);
    chk("R5 ack at zero", 64'(irq_ipi), 0);
    chk("R5 no err", 64'(wr_err), 0);
  endtask

  task automatic t_mixed;
    cyc(1, 64'h1100, 0);
    chk("R6 zero", 64'(irq_ipi), 0);
    chk("R6 stat", rd_data, 0);
    cyc(1, 64'h1000, 0);
    cyc(1, 64'h1100, 0);
    chk("R6 one", 64'(irq_ipi), 64'h1);
    cyc(1, 64'h100, 0);
    chk("R6 drain", 64'(irq_ipi), 0);
    cpu_present = 4'b1000;
    cyc(0, 0, 1);
    cyc(1, 64'h4080, 0);
    chk("R6 clr+req tmr", 64'(irq_timer), 0);
    chk("R6 clr+req ipi", 64'(irq_ipi), 64'h4);
    cyc(1, 64'h400, 0);
  endtask

  task automatic t_err;
    cyc(1, 64'h1000, 0);
    cyc(1, 64'hFFFF_0000_0000_000F, 0);
    chk("R7 pulse", 64'(wr_err), 1);
    chk("R7 state", rd_data, 64'h100);
    chk("R7 ipi", 64'(irq_ipi), 64'h1);
    @(negedge clk);
    chk("R7 one cycle", 64'(wr_err), 0);
    cyc(1, 64'h100, 0);
  endtask

  task automatic t_sat;
    for (int k = 0; k < 256; k++) cyc(1, 64'h8000, 0);
    chk("R8 after 256", 64'(irq_ipi), 64'h8);
    for (int k = 0; k < 254; k++) cyc(1, 64'h800, 0);
    chk("R8 after 254 acks", 64'(irq_ipi), 64'h8);
    cyc(1, 64'h800, 0);
    chk("R8 after 255 acks", 64'(irq_ipi), 0);
  endtask

  task automatic t_read;
    cyc(1, 64'hFFFF_FFFF_FFFF_F00F, 0);
    chk("R9 mask", rd_data, 64'hF00);
    cyc(1, 64'hF00, 0);
    chk("R9 cleanup", 64'(irq_ipi), 0);
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_timer();
    t_tick_clear();
    t_ipi();
    t_mixed();
    t_err();
    t_sat();
    t_read();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule